// File: doc/BRIEF.md
# Per-Stream Output Advancement Unit

This block sets the output timing of a group of serial data streams relative to a shared frame pulse. Every serial input and the frame pulse enter the same delay line. That line has a fixed depth, so the frame pulse output and any stream left at its default setting come out with the same, known latency. A stream can be moved earlier by one, two or three cycles of the fast system clock. To do this the unit takes that stream from an earlier stage of the delay line, so the stream leads the frame pulse output by the programmed number of cycles.

Each stream has its own small configuration register, reached through a simple synchronous port with address, write data, write enable and read data. The registers occupy a contiguous address window. A value written to a register is held there first. It is only used for the stream at the next input frame pulse, so a stream never changes its alignment in the middle of a frame.

Top module: `stream_advance_unit`

## Requirements
- R1: While reset is high and on the cycle it is released, every serial output, the frame pulse output and the read data are zero.
- R2: The register for stream n sits at address BASE_ADDR + n, with BASE_ADDR = 0x0083 and 16 streams, so the window runs up to 0x0092. A read returns the register in read data bits 1:0 on the cycle after the address is presented.
- R3: Write data bits 15:2 are discarded, and read data bits 15:2 are always zero.
- R4: An address outside the window returns zero on a read. A write to such an address changes no register.
- R5: The frame pulse output equals the frame pulse input as sampled three clock edges earlier.
- R6: A stream whose active code is 0 equals its input as sampled three clock edges earlier, so it is aligned with the frame pulse output.
- R7: A stream whose active code is k (1, 2 or 3) equals its input as sampled 3 - k edges earlier. This puts it k cycles ahead of the frame pulse output. Code 3 gives the input of the current edge, registered once.
- R8: A written code becomes the active code at a clock edge where the frame pulse input is high. That edge itself still uses the old code. At all other edges the active code does not change.
- R9: Each stream follows its own active code, whatever codes the other streams have.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 16 | Registered read data |
| ser_in | input | 16 | Serial stream inputs, one bit per stream |
| fp_in | input | 1 | Frame pulse input |
| ser_out | output | 16 | Advanced serial stream outputs |
| fp_out | output | 1 | Delayed frame pulse output |

## Verification
The bench builds the unit with its default parameters: 16 streams, 2-bit codes, a three-stage delay line and a window based at 0x0083. With these values all four tap positions can be in use at once across the streams. The addresses just below and just above the window, as well as 0x0000 and 0xFFFF, are within reach. Codes are reprogrammed both with and without a following frame pulse, which shows when a new code is taken up.

// File: rtl/adv_pkg.sv
package adv_pkg;

  // Stage of the delay line that feeds a stream with the given code.
  // Stage 0 is the undelayed input; codes beyond the depth clamp to stage 0.
  function automatic int tap_stage(input int code, input int depth);
    if (code > depth) return 0;
    return depth - code;
  endfunction

endpackage

// File: rtl/adv_regfile.sv
module adv_regfile #(
  parameter int unsigned N_STREAMS = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CODE_W    = 2,
  parameter int unsigned BASE_ADDR = 'h83
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_pulse,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [DATA_W-1:0]           cfg_wdata,
  input  logic                        cfg_we,
  output logic [DATA_W-1:0]           cfg_rdata,
  output logic [N_STREAMS*CODE_W-1:0] act_codes
);

  localparam int unsigned IDX_W = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1;
  localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] COUNT_V = ADDR_W'(N_STREAMS);

  logic [N_STREAMS*CODE_W-1:0] cfg_flat;
  logic [ADDR_W-1:0]           off;
  logic [IDX_W-1:0]            idx;
  logic                        hit;

  assign off = cfg_addr - BASE_V;
  assign hit = (cfg_addr >= BASE_V) && (off < COUNT_V);
  assign idx = off[IDX_W-1:0];

  // Programmed codes: only the code field of the write data is stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_flat <= '0;
    end else if (cfg_we && hit) begin
      for (int n = 0; n < int'(N_STREAMS); n++) begin
        if (idx == IDX_W'(n)) cfg_flat[n*CODE_W +: CODE_W] <= cfg_wdata[CODE_W-1:0];
      end
    end
  end

  // Registered read path; reserved upper bits come out as zero.
  always_ff @(posedge clk) begin
    if (rst)      cfg_rdata <= '0;
    else if (hit) cfg_rdata <= DATA_W'(cfg_flat[idx*CODE_W +: CODE_W]);
    else          cfg_rdata <= '0;
  end

  // Active codes are taken over only on a frame pulse.
  always_ff @(posedge clk) begin
    if (rst)              act_codes <= '0;
    else if (frame_pulse) act_codes <= cfg_flat;
  end

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[DATA_W-1:CODE_W] == '0);

  assert_oor_write_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !hit) |=> $stable(cfg_flat));

  assert_oor_read_R4: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (cfg_rdata == '0));

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_pulse |=> $stable(act_codes));

endmodule

// File: rtl/adv_delay_line.sv
module adv_delay_line #(
  parameter int unsigned WIDTH = 17,
  parameter int unsigned DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WIDTH-1:0]           din,
  output logic [(DEPTH+1)*WIDTH-1:0] taps
);

  assign taps[WIDTH-1:0] = din;

  for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= taps[(s-1)*WIDTH +: WIDTH];
    end
    assign taps[s*WIDTH +: WIDTH] = q;
  end

endmodule

// File: rtl/adv_tap_mux.sv
module adv_tap_mux #(
  parameter int unsigned N_STREAMS = 16,
  parameter int unsigned DEPTH     = 3,
  parameter int unsigned CODE_W    = 2
) (
  input  logic [(DEPTH+1)*(N_STREAMS+1)-1:0] taps,
  input  logic [N_STREAMS*CODE_W-1:0]        codes,
  output logic [N_STREAMS-1:0]               sel_out
);
  import adv_pkg::*;

  localparam int unsigned W = N_STREAMS + 1;

  for (genvar n = 0; n < N_STREAMS; n++) begin : g_lane
    logic [CODE_W-1:0] code;
    assign code = codes[n*CODE_W +: CODE_W];
    always_comb begin
      sel_out[n] = taps[n];
      for (int j = 0; j <= int'(DEPTH); j++) begin
        if (tap_stage(int'(code), int'(DEPTH)) == j) sel_out[n] = taps[j*W + n];
      end
    end
  end

endmodule

// File: rtl/stream_advance_unit.sv
module stream_advance_unit #(
  parameter int unsigned N_STREAMS = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CODE_W    = 2,
  parameter int unsigned BASE_ADDR = 'h83
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic                 reg_we,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [N_STREAMS-1:0] ser_in,
  input  logic                 fp_in,
  output logic [N_STREAMS-1:0] ser_out,
  output logic                 fp_out
);

  localparam int unsigned DEPTH = (1 << CODE_W) - 1;
  localparam int unsigned W     = N_STREAMS + 1;
  localparam int unsigned LAT   = DEPTH + 1;
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  logic [N_STREAMS*CODE_W-1:0] act_codes;
  logic [(DEPTH+1)*W-1:0]      taps;
  logic [N_STREAMS-1:0]        lane_sel;

  adv_regfile #(
    .N_STREAMS(N_STREAMS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CODE_W(CODE_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .frame_pulse(fp_in),
    .cfg_addr(reg_addr), .cfg_wdata(reg_wdata), .cfg_we(reg_we),
    .cfg_rdata(reg_rdata), .act_codes(act_codes)
  );

  adv_delay_line #(.WIDTH(W), .DEPTH(DEPTH)) u_line (
    .clk(clk), .rst(rst), .din({fp_in, ser_in}), .taps(taps)
  );

  adv_tap_mux #(.N_STREAMS(N_STREAMS), .DEPTH(DEPTH), .CODE_W(CODE_W)) u_mux (
    .taps(taps), .codes(act_codes), .sel_out(lane_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out <= '0;
      fp_out  <= 1'b0;
    end else begin
      ser_out <= lane_sel;
      fp_out  <= taps[DEPTH*W + N_STREAMS];
    end
  end

  // Cycles since reset release, saturating; gates the latency check.
  logic [CNT_W-1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)                     warm <= '0;
    else if (warm < CNT_W'(LAT)) warm <= warm + 1'b1;
  end

  assert_fp_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (warm >= CNT_W'(LAT)) |-> (fp_out == $past(fp_in, LAT)));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (ser_out == '0 && !fp_out && reg_rdata == '0));

endmodule

// File: tb/stream_advance_unit_test.sv
`timescale 1ns/1ps
module stream_advance_unit_test;
  localparam int N = 16;
  localparam int BASE = 'h83;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reg_addr = '0, reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_rdata;
  logic [N-1:0] ser_in = '0;
  logic        fp_in = 1'b0;
  logic [N-1:0] ser_out;
  logic        fp_out;

  always #2 clk = ~clk;

  stream_advance_unit uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .ser_in(ser_in), .fp_in(fp_in),
    .ser_out(ser_out), .fp_out(fp_out)
  );

  int total = 0, bad = 0;
  logic done = 1'b0;

  // Reference model state
  logic [N:0]  hist [4];
  logic [1:0]  cfg_m [N];
  logic [1:0]  act_m [N];
  logic [1:0]  act_used [N];
  logic [15:0] exp_rd;
  logic [15:0] lf = 16'hACE1;

  // Each entry: address, write data, expected read-back
  localparam logic [47:0] TV [8] = '{
    48'h0083_0001_0001, 48'h0092_FFFF_0003, 48'h0084_0006_0002,
    48'h0082_0003_0000, 48'h0093_0002_0000, 48'h008A_ABCD_0001,
    48'h0000_0003_0000, 48'hFFFF_0002_0000
  };

  function automatic bit in_win(input logic [15:0] a);
    return int'(a) >= BASE && int'(a) < BASE + N;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int h = 0; h < 4; h++) hist[h] = '0;
    for (int n = 0; n < N; n++) begin
      cfg_m[n] = '0; act_m[n] = '0; act_used[n] = '0;
    end
    exp_rd = '0;
  endtask

  task automatic check_outputs();
    chk("R5 frame pulse", 32'(fp_out), 32'(hist[3][N]));
    for (int n = 0; n < N; n++) begin
      int k = int'(act_used[n]);
      chk(k == 0 ? "R6 R9 stream" : "R7 R9 stream", 32'(ser_out[n]), 32'(hist[3-k][n]));
    end
    chk("R2 R3 R4 read data", 32'(reg_rdata), 32'(exp_rd));
  endtask

  task automatic cyc(input logic [N-1:0] d, input logic fp, input logic we,
                     input logic [15:0] a, input logic [15:0] wd);
    @(negedge clk);
    check_outputs();
    ser_in = d; fp_in = fp; reg_we = we; reg_addr = a; reg_wdata = wd;
    for (int h = 3; h > 0; h--) hist[h] = hist[h-1];
    hist[0] = {fp, d};
    exp_rd = in_win(a) ? {14'b0, cfg_m[int'(a) - BASE]} : 16'h0;
    for (int n = 0; n < N; n++) begin
      act_used[n] = act_m[n];
      if (fp) act_m[n] = cfg_m[n];   // R8: load at a pulsed edge, used from the next
    end
    if (we && in_win(a)) cfg_m[int'(a) - BASE] = wd[1:0];
  endtask

  task automatic next_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic run(input int cycles, input int fp_period);
    for (int c = 0; c < cycles; c++) begin
      next_lf();
      cyc(lf, (fp_period > 0) && (c % fp_period == 0), 1'b0, 16'h0, 16'h0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ser_in = '0; fp_in = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: everything cleared while in reset
    chk("R1 reset ser_out", 32'(ser_out), 32'h0);
    chk("R1 reset fp_out", 32'(fp_out), 32'h0);
    chk("R1 reset rdata", 32'(reg_rdata), 32'h0);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    model_clear();
    do_reset();

    // Table walk: write, read back, compare (R2, R3, R4)
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a, w, e;
      {a, w, e} = TV[i];
      cyc('0, 1'b0, 1'b1, a, w);
      cyc('0, 1'b0, 1'b0, a, 16'h0);
      cyc('0, 1'b0, 1'b0, 16'h0, 16'h0);
      chk(in_win(a) ? "R2 R3 table read" : "R4 table read", 32'(reg_rdata), 32'(e));
    end

    // R9: all four codes at once across streams; R8: not active before a pulse
    for (int n = 0; n < N; n++) begin
      next_lf();
      cyc(lf, 1'b0, 1'b1, 16'(BASE + n), 16'(n % 4));
    end
    run(8, 0);
    run(24, 12);

    // Reprogram without a pulse: old codes stay in use (R8)
    for (int n = 0; n < N; n++) begin
      next_lf();
      cyc(lf, 1'b0, 1'b1, 16'(BASE + n), 16'(3 - (n % 4)));
    end
    run(8, 0);
    next_lf();
    cyc(lf, 1'b1, 1'b0, 16'h0, 16'h0);
    run(24, 7);

    // Read back every register after reprogramming (R2)
    for (int n = 0; n < N; n++) cyc('0, 1'b0, 1'b0, 16'(BASE + n), 16'h0);
    cyc('0, 1'b0, 1'b0, 16'h0, 16'h0);

    // Mid-run reset clears registers and pipeline (R1), then code-0 streams (R6)
    do_reset();
    cyc('0, 1'b0, 1'b0, 16'(BASE + 5), 16'h0);
    cyc('0, 1'b0, 1'b0, 16'h0, 16'h0);
    chk("R1 register after reset", 32'(reg_rdata), 32'h0);
    run(20, 5);

    // All streams at maximum advance, dense pulses (R7)
    for (int n = 0; n < N; n++) cyc('1, 1'b0, 1'b1, 16'(BASE + n), 16'h3);
    run(20, 3);
    run(4, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule